// File: doc/BRIEF.md
# Pixel Layer Compositor with Column Clipping and Grayscale

This block is the last per-pixel stage of a tile-and-sprite video pipeline. Every cycle it receives one background pixel and one sprite pixel, each as a 2-bit pattern value and an already resolved 6-bit color. It also receives a sprite-behind flag, the horizontal screen column, the 6-bit backdrop color and an 8-bit control byte. The control byte enables each layer, and it can hide each layer separately in the leftmost eight screen columns.

The block decides which layer is visible and substitutes the backdrop color where neither layer shows. When grayscale is requested, it reduces the chosen color to its luminance bits. The three color-emphasis bits of the control byte go to the output unchanged. The result is registered, with one cycle of latency, and carries a valid strobe.

The control byte is laid out as follows. Bit 0 selects grayscale. Bit 1 shows the background in columns 0–7. Bit 2 shows sprites in columns 0–7. Bit 3 enables the background. Bit 4 enables sprites. Bits 7:5 are the emphasis bits.

Top module: `pixc_stage`

## Requirements
- R1: A background pixel is visible only when control bit 3 is 1 and its pattern value is nonzero.
- R2: A sprite pixel is visible only when control bit 4 is 1 and its pattern value is nonzero.
- R3: With control bit 1 at 0, the background is not visible in columns 0–7 but is visible again from column 8 on. With bit 1 at 1, it is visible in every column.
- R4: With control bit 2 at 0, sprites are not visible in columns 0–7 but are visible again from column 8 on. With bit 2 at 1, they are visible in every column.
- R5: A visible sprite with the behind flag at 0 is output in place of a visible background pixel.
- R6: A visible sprite with the behind flag at 1 is output only where the background is not visible. Otherwise the background color is output.
- R7: When neither layer is visible, the backdrop color is output.
- R8: With control bit 0 at 1, the output color is the selected color ANDed with 6'h30. With bit 0 at 0, the selected color is output unchanged.
- R9: out_emph equals control bits 7:5 of the same pixel, whatever the grayscale bit is.
- R10: out_color, out_emph and out_valid appear exactly one clock after the inputs are sampled. Reset drives all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs hold a pixel this cycle |
| col | input | 8 | Horizontal screen column |
| ctrl | input | 8 | Control byte (layout in the description above) |
| bg_pat | input | 2 | Background pattern value, 0 is transparent |
| bg_color | input | 6 | Background resolved color |
| spr_pat | input | 2 | Sprite pattern value, 0 is transparent |
| spr_color | input | 6 | Sprite resolved color |
| spr_behind | input | 1 | Sprite is placed behind the background |
| backdrop | input | 6 | Backdrop color used when no layer shows |
| out_valid | output | 1 | Output pixel valid |
| out_color | output | 6 | Final color index |
| out_emph | output | 3 | Emphasis bits (blue, green, red) |

## Verification
Column clipping and layer priority can act on the same pixel. The bench provokes this with an opaque background and an opaque sprite, alternating the behind flag, across columns 0 through 9 and across all sixteen settings of the enable and left-column bits. Clipping must be resolved before priority: a clipped front sprite must uncover the background, and a clipped background must let a behind sprite through. Grayscale and emphasis fall on the same output word. They are toggled within the same sweep, and each output pixel is judged against an expected color and emphasis that the bench model computes independently.

// File: rtl/pixc_pkg.sv
package pixc_pkg;
    parameter int COLOR_W = 6;
    parameter int EMPH_W  = 3;
    parameter int CTRL_W  = 8;

    // control byte field positions
    localparam int CB_GRAY    = 0;
    localparam int CB_BG_LEFT = 1;
    localparam int CB_SP_LEFT = 2;
    localparam int CB_BG_EN   = 3;
    localparam int CB_SP_EN   = 4;
    localparam int CB_EMPH_LO = 5;

    localparam logic [COLOR_W-1:0] GRAY_KEEP = 6'h30;

    typedef struct packed {
        logic               valid;
        logic [COLOR_W-1:0] color;
        logic [EMPH_W-1:0]  emph;
    } pix_out_t;
endpackage

// File: rtl/pixc_layer_gate.sv
module pixc_layer_gate #(
    parameter int PAT_W     = 2,
    parameter int COL_W     = 8,
    parameter int CLIP_COLS = 8
) (
    input  logic [PAT_W-1:0] pat,
    input  logic [COL_W-1:0] col,
    input  logic             enable,
    input  logic             show_left,
    output logic             visible
);
    localparam logic [COL_W-1:0] CLIP_LIMIT = COL_W'(CLIP_COLS);

    logic opaque;
    logic in_clip_zone;

    always_comb begin
        opaque       = (pat != '0);
        in_clip_zone = (col < CLIP_LIMIT);
        visible      = enable && opaque && (show_left || !in_clip_zone);
    end
endmodule

// File: rtl/pixc_select.sv
module pixc_select #(
    parameter int COLOR_W = 6
) (
    input  logic               bg_vis,
    input  logic               sp_vis,
    input  logic               sp_behind,
    input  logic [COLOR_W-1:0] bg_color,
    input  logic [COLOR_W-1:0] sp_color,
    input  logic [COLOR_W-1:0] backdrop,
    output logic [COLOR_W-1:0] color
);
    always_comb begin
        if (sp_vis && (!sp_behind || !bg_vis)) begin
            color = sp_color;
        end else if (bg_vis) begin
            color = bg_color;
        end else begin
            color = backdrop;
        end
    end
endmodule

// File: rtl/pixc_stage.sv
module pixc_stage
    import pixc_pkg::*;
#(
    parameter int COL_W     = 8,
    parameter int PAT_W     = 2,
    parameter int CLIP_COLS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COL_W-1:0]   col,
    input  logic [CTRL_W-1:0]  ctrl,
    input  logic [PAT_W-1:0]   bg_pat,
    input  logic [COLOR_W-1:0] bg_color,
    input  logic [PAT_W-1:0]   spr_pat,
    input  logic [COLOR_W-1:0] spr_color,
    input  logic               spr_behind,
    input  logic [COLOR_W-1:0] backdrop,
    output logic               out_valid,
    output logic [COLOR_W-1:0] out_color,
    output logic [EMPH_W-1:0]  out_emph
);
    localparam int NUM_LAYERS = 2;   // 0 = background, 1 = sprite

    logic [PAT_W-1:0] layer_pat  [NUM_LAYERS];
    logic             layer_en   [NUM_LAYERS];
    logic             layer_left [NUM_LAYERS];
    logic             layer_vis  [NUM_LAYERS];
    logic [COLOR_W-1:0] sel_color;

    always_comb begin
        layer_pat[0]  = bg_pat;
        layer_en[0]   = ctrl[CB_BG_EN];
        layer_left[0] = ctrl[CB_BG_LEFT];
        layer_pat[1]  = spr_pat;
        layer_en[1]   = ctrl[CB_SP_EN];
        layer_left[1] = ctrl[CB_SP_LEFT];
    end

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
        pixc_layer_gate #(
            .PAT_W    (PAT_W),
            .COL_W    (COL_W),
            .CLIP_COLS(CLIP_COLS)
        ) u_gate (
            .pat      (layer_pat[g]),
            .col      (col),
            .enable   (layer_en[g]),
            .show_left(layer_left[g]),
            .visible  (layer_vis[g])
        );
    end

    pixc_select #(.COLOR_W(COLOR_W)) u_select (
        .bg_vis   (layer_vis[0]),
        .sp_vis   (layer_vis[1]),
        .sp_behind(spr_behind),
        .bg_color (bg_color),
        .sp_color (spr_color),
        .backdrop (backdrop),
        .color    (sel_color)
    );

    pix_out_t st_d, st_q;

    always_comb begin
        st_d.valid = in_valid;
        st_d.color = ctrl[CB_GRAY] ? (sel_color & GRAY_KEEP) : sel_color;
        st_d.emph  = ctrl[CB_EMPH_LO +: EMPH_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_color = st_q.color;
    assign out_emph  = st_q.emph;

    // R10: valid strobe follows the input strobe by one cycle
    assert_valid_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: grayscale leaves only the luminance bits set
    assert_gray_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl[CB_GRAY]) |=> ((out_color & ~GRAY_KEEP) == '0));

    // R9: emphasis passes through regardless of grayscale
    assert_emph_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_emph == $past(ctrl[CB_EMPH_LO +: EMPH_W])));

    // R7: both layers disabled yields the backdrop color
    assert_backdrop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctrl[CB_BG_EN] && !ctrl[CB_SP_EN] && !ctrl[CB_GRAY])
        |=> (out_color == $past(backdrop)));
endmodule

// File: tb/tb_pixc_stage.sv
module tb_pixc_stage;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] col = '0;
    logic [7:0] ctrl = '0;
    logic [1:0] bg_pat = '0;
    logic [5:0] bg_color = '0;
    logic [1:0] spr_pat = '0;
    logic [5:0] spr_color = '0;
    logic       spr_behind = 1'b0;
    logic [5:0] backdrop = '0;
    logic       out_valid;
    logic [5:0] out_color;
    logic [2:0] out_emph;

    always #10 clk = ~clk;   // 50 MHz

    pixc_stage dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .col(col), .ctrl(ctrl),
        .bg_pat(bg_pat), .bg_color(bg_color), .spr_pat(spr_pat),
        .spr_color(spr_color), .spr_behind(spr_behind), .backdrop(backdrop),
        .out_valid(out_valid), .out_color(out_color), .out_emph(out_emph)
    );

    typedef struct {
        logic [5:0] color;
        logic [2:0] emph;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int failures = 0;
    int cycle = 0;
    bit finished = 0;

    always @(posedge clk) cycle <= cycle + 1;

    function automatic logic [5:0] model(input logic [7:0] c, input logic [7:0] cb,
                                         input logic [1:0] bp, input logic [5:0] bc,
                                         input logic [1:0] sp, input logic [5:0] sc,
                                         input logic beh, input logic [5:0] bd);
        logic bv, sv;
        logic [5:0] r;
        bv = cb[3] && (bp != 0) && (cb[1] || c >= 8);
        sv = cb[4] && (sp != 0) && (cb[2] || c >= 8);
        if (sv && !(beh && bv)) r = sc;
        else if (bv)            r = bc;
        else                    r = bd;
        if (cb[0]) r = r & 6'h30;
        return r;
    endfunction

    task automatic drive(input logic [7:0] c, input logic [7:0] cb,
                         input logic [1:0] bp, input logic [5:0] bc,
                         input logic [1:0] sp, input logic [5:0] sc,
                         input logic beh, input logic [5:0] bd, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; col = c; ctrl = cb; bg_pat = bp; bg_color = bc;
        spr_pat = sp; spr_color = sc; spr_behind = beh; backdrop = bd;
        e.color = model(c, cb, bp, bc, sp, sc, beh, bd);
        e.emph  = cb[7:5];
        e.cyc   = cycle;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compares results as they appear, one cycle after the push
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R10 unexpected out_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (out_color !== e.color) begin
                    failures++;
                    $display("FAIL %s color actual=%h expected=%h", e.tag, out_color, e.color);
                end
                checks++;
                if (out_emph !== e.emph) begin
                    failures++;
                    $display("FAIL R9 emph actual=%b expected=%b", out_emph, e.emph);
                end
                checks++;
                if (cycle != e.cyc + 1) begin
                    failures++;
                    $display("FAIL R10 latency actual=%0d expected=%0d", cycle - e.cyc, 1);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (out_valid !== 1'b0 || out_color !== 6'h00 || out_emph !== 3'b000) begin
            failures++;
            $display("FAIL R10 reset actual=%b/%h/%b expected=0/00/000",
                     out_valid, out_color, out_emph);
        end
        @(negedge clk); rst_n = 1'b1;
        idle();

        // R1: background disabled or transparent
        drive(8'd20, 8'h08, 2'd1, 6'h2A, 2'd0, 6'h15, 1'b0, 6'h0F, "R1");
        drive(8'd20, 8'h00, 2'd1, 6'h2A, 2'd0, 6'h15, 1'b0, 6'h0F, "R1");
        drive(8'd20, 8'h08, 2'd0, 6'h2A, 2'd0, 6'h15, 1'b0, 6'h0F, "R1");
        // R2: sprite enable and transparency
        drive(8'd20, 8'h10, 2'd0, 6'h2A, 2'd2, 6'h15, 1'b0, 6'h0F, "R2");
        drive(8'd20, 8'h00, 2'd0, 6'h2A, 2'd2, 6'h15, 1'b0, 6'h0F, "R2");
        drive(8'd20, 8'h18, 2'd1, 6'h2A, 2'd0, 6'h15, 1'b0, 6'h0F, "R2");
        idle();
        // R3/R4 boundary at columns 7 and 8
        drive(8'd7, 8'h08, 2'd1, 6'h2A, 2'd0, 6'h15, 1'b0, 6'h0F, "R3");
        drive(8'd8, 8'h08, 2'd1, 6'h2A, 2'd0, 6'h15, 1'b0, 6'h0F, "R3");
        drive(8'd0, 8'h0A, 2'd1, 6'h2A, 2'd0, 6'h15, 1'b0, 6'h0F, "R3");
        drive(8'd7, 8'h10, 2'd0, 6'h2A, 2'd3, 6'h15, 1'b0, 6'h0F, "R4");
        drive(8'd8, 8'h10, 2'd0, 6'h2A, 2'd3, 6'h15, 1'b0, 6'h0F, "R4");
        drive(8'd0, 8'h14, 2'd0, 6'h2A, 2'd3, 6'h15, 1'b0, 6'h0F, "R4");
        // R5/R6 priority
        drive(8'd30, 8'h18, 2'd1, 6'h2A, 2'd1, 6'h15, 1'b0, 6'h0F, "R5");
        drive(8'd30, 8'h18, 2'd1, 6'h2A, 2'd1, 6'h15, 1'b1, 6'h0F, "R6");
        drive(8'd30, 8'h18, 2'd0, 6'h2A, 2'd1, 6'h15, 1'b1, 6'h0F, "R6");
        // R7 backdrop
        drive(8'd30, 8'h18, 2'd0, 6'h2A, 2'd0, 6'h15, 1'b0, 6'h1B, "R7");
        drive(8'd3, 8'h18, 2'd2, 6'h2A, 2'd2, 6'h15, 1'b0, 6'h1B, "R7");
        // R8 grayscale, R9 emphasis survives grayscale
        drive(8'd30, 8'hE9, 2'd1, 6'h3F, 2'd0, 6'h15, 1'b0, 6'h0F, "R8");
        drive(8'd30, 8'hA1, 2'd0, 6'h2A, 2'd0, 6'h15, 1'b0, 6'h3F, "R8");
        drive(8'd30, 8'h48, 2'd1, 6'h3F, 2'd0, 6'h15, 1'b0, 6'h0F, "R8");
        idle(); idle();

        // combined sweep: clipping, priority, grayscale and emphasis together
        for (int c = 0; c < 10; c++) begin
            for (int m = 0; m < 16; m++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [7:0] cb;
                    cb = {3'((c + m + g) % 8), 4'(m), 1'(g)};
                    drive(8'(c), cb, 2'd1, 6'h2A, 2'd3, 6'h15, 1'(m ^ c),
                          6'h0F, "R1_R2_R3_R4_R5_R6_R8");
                end
            end
            idle();
        end
        idle(); idle();

        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R10 pending actual=%0d expected=0", q.size());
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule